// File: doc/BRIEF.md
# Four-Phase Pipelined Instruction Sequencer

This block provides the timing skeleton of a small two-stage fetch/execute processor. Each instruction cycle is cut into four sub-phases, Q1 to Q4, produced by an enumerated ring state machine with the states `PH_Q1`, `PH_Q2`, `PH_Q3` and `PH_Q4`. The transitions are `PH_Q1 -> PH_Q2`, `PH_Q2 -> PH_Q3`, `PH_Q3 -> PH_Q4` and the wrap `PH_Q4 -> PH_Q1`, which closes one instruction cycle. Reset forces `PH_Q1`.

While one word executes, the word behind it is fetched. A fetch buffer captures the program-memory word at the end of Q3. At the close of Q4 that word moves into the instruction register, which then holds it for the whole next cycle. The block drives strobes for the surrounding datapath: program-counter advance in Q1, instruction-register load in Q1, operand read in Q2 and destination write in Q4.

The execute logic raises a flow-change flag when the executing instruction is a jump or branch. The sequencer samples that flag at the end of Q4. If the flag is set, the prefetched word is replaced by a no-operation for the next cycle, and the branch target is fetched during that flushed cycle.

Top module: `qphase_seq`

## Requirements
- R1: While reset is low, and in the first instruction cycle after it is released, the phase is Q1 (only `q1` high), `ir_word` equals the no-operation code 0, `exec_valid` is 0, and `op_rd` and `dst_wr` stay 0.
- R2: Exactly one of `q1`..`q4` is high in every clock. The sequence is Q1, Q2, Q3, Q4, then back to Q1, advancing one phase per clock.
- R3: `pc_adv` and `ir_load` are high in Q1 of every instruction cycle, flushed cycles included, and low in every other phase.
- R4: `instr_word` is sampled only on the clock edge that ends Q3. `ir_word` and `exec_valid` change only on the edge that ends Q4 and stay constant from Q1 through Q4 of the cycle that follows. A change of `instr_word` during Q4 has no effect.
- R5: `op_rd` is high exactly in Q2 and `dst_wr` exactly in Q4 of a cycle with `exec_valid` = 1. Both stay low in flushed cycles.
- R6: In straight-line code, the word fetched in cycle k appears in `ir_word` with `exec_valid` = 1 in cycle k+1, so one instruction completes per cycle.
- R7: If `flow_change` is 1 at the end of Q4 while `exec_valid` is 1, the next cycle is a flush: `ir_word` = 0 and `exec_valid` = 0. The branch therefore costs two cycles.
- R8: The word fetched during a flush cycle (the branch target) executes in the following cycle with `exec_valid` = 1, including when that target is itself a branch.
- R9: `flow_change` is ignored in Q1, Q2 and Q3, and also at the end of Q4 of a flushed cycle (`exec_valid` = 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock; one edge per sub-phase |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_word | input | IW (16) | Word returned by program memory for the current fetch |
| flow_change | input | 1 | Execute logic reports a program-counter change |
| q1 | output | 1 | Phase strobe Q1 |
| q2 | output | 1 | Phase strobe Q2 |
| q3 | output | 1 | Phase strobe Q3 |
| q4 | output | 1 | Phase strobe Q4 |
| pc_adv | output | 1 | Program-counter advance strobe |
| ir_load | output | 1 | Instruction register freshly loaded |
| op_rd | output | 1 | Data-memory operand read strobe |
| dst_wr | output | 1 | Destination write strobe |
| ir_word | output | IW (16) | Instruction register contents |
| exec_valid | output | 1 | Current cycle executes a real instruction |

## Verification
The bench targets back-to-back branches, where the target of one branch is itself a branch. A design that let a flushed slot raise another flush would squash the second target as well. A stray flow-change pulse early in a cycle and a forced flag during a flushed cycle must both leave execution alone; a design that sampled the flag in the wrong phase, or ignored `exec_valid` when sampling it, would drop a good instruction. The memory word is corrupted during Q4 of every cycle, so a fetch buffer that sampled at the wrong edge would show the wrong word one cycle later. The first cycle after reset is checked for idle strobes, which catches an instruction register that does not reset to a no-operation.

// File: rtl/qps_pkg.sv
`timescale 1ns/1ps
package qps_pkg;
    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } phase_e;

    localparam int NUM_PHASES = 4;
endpackage

// File: rtl/qps_phase_fsm.sv
`timescale 1ns/1ps
module qps_phase_fsm
    import qps_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [NUM_PHASES-1:0] phase_oh,
    output logic                  end_fetch,
    output logic                  end_cycle
);
    phase_e state_q;
    phase_e state_d;

    always_comb begin
        unique case (state_q)
            PH_Q1: state_d = PH_Q2;
            PH_Q2: state_d = PH_Q3;
            PH_Q3: state_d = PH_Q4;
            PH_Q4: state_d = PH_Q1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_Q1;
        else        state_q <= state_d;
    end

    always_comb begin
        phase_oh  = '0;
        end_fetch = 1'b0;
        end_cycle = 1'b0;
        unique case (state_q)
            PH_Q1: phase_oh[0] = 1'b1;
            PH_Q2: phase_oh[1] = 1'b1;
            PH_Q3: begin
                phase_oh[2] = 1'b1;
                end_fetch   = 1'b1;
            end
            PH_Q4: begin
                phase_oh[3] = 1'b1;
                end_cycle   = 1'b1;
            end
        endcase
    end

    p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_oh) == 1);
    p_q1_to_q2_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[0] |=> phase_oh[1]);
    p_q2_to_q3_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[1] |=> phase_oh[2]);
    p_q3_to_q4_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[2] |=> phase_oh[3]);
    p_q4_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[3] |=> phase_oh[0]);
endmodule

// File: rtl/qps_fetch_buf.sv
`timescale 1ns/1ps
module qps_fetch_buf #(
    parameter int          IW       = 16,
    parameter logic [IW-1:0] NOP_CODE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          end_fetch,
    input  logic [IW-1:0] mem_word,
    output logic [IW-1:0] fetched
);
    always_ff @(posedge clk) begin
        if (!rst_n)         fetched <= NOP_CODE;
        else if (end_fetch) fetched <= mem_word;
    end

    p_fetch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !end_fetch |=> $stable(fetched));
endmodule

// File: rtl/qps_exec_reg.sv
`timescale 1ns/1ps
module qps_exec_reg #(
    parameter int            IW       = 16,
    parameter logic [IW-1:0] NOP_CODE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          end_cycle,
    input  logic          flow_change,
    input  logic [IW-1:0] fetched,
    output logic [IW-1:0] ir,
    output logic          valid
);
    logic squash;

    // a squashed (no-op) slot cannot itself request a flush
    assign squash = flow_change & valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir    <= NOP_CODE;
            valid <= 1'b0;
        end else if (end_cycle) begin
            ir    <= squash ? NOP_CODE : fetched;
            valid <= ~squash;
        end
    end

    p_ir_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !end_cycle |=> ($stable(ir) && $stable(valid)));
    p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (end_cycle && flow_change && valid) |=> (!valid && ir == NOP_CODE));
    p_straight_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (end_cycle && !flow_change) |=> valid);
    p_flush_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (end_cycle && !valid) |=> valid);
endmodule

// File: rtl/qps_strobes.sv
`timescale 1ns/1ps
module qps_strobes
    import qps_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PHASES-1:0] phase_oh,
    input  logic                  valid,
    output logic                  pc_adv,
    output logic                  ir_load,
    output logic                  op_rd,
    output logic                  dst_wr
);
    always_comb begin
        pc_adv  = phase_oh[0];
        ir_load = phase_oh[0];
        op_rd   = phase_oh[1] & valid;
        dst_wr  = phase_oh[3] & valid;
    end

    p_rd_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_rd |=> (!op_rd && !dst_wr));
    p_wr_then_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dst_wr |=> pc_adv);
    p_adv_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pc_adv |=> !pc_adv);
endmodule

// File: rtl/qphase_seq.sv
`timescale 1ns/1ps
module qphase_seq
    import qps_pkg::*;
#(
    parameter int            IW       = 16,
    parameter logic [IW-1:0] NOP_CODE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] instr_word,
    input  logic          flow_change,
    output logic          q1,
    output logic          q2,
    output logic          q3,
    output logic          q4,
    output logic          pc_adv,
    output logic          ir_load,
    output logic          op_rd,
    output logic          dst_wr,
    output logic [IW-1:0] ir_word,
    output logic          exec_valid
);
    logic [NUM_PHASES-1:0] phase_oh;
    logic                  end_fetch;
    logic                  end_cycle;
    logic [IW-1:0]         fetched;

    qps_phase_fsm u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_oh  (phase_oh),
        .end_fetch (end_fetch),
        .end_cycle (end_cycle)
    );

    qps_fetch_buf #(.IW(IW), .NOP_CODE(NOP_CODE)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .end_fetch (end_fetch),
        .mem_word  (instr_word),
        .fetched   (fetched)
    );

    qps_exec_reg #(.IW(IW), .NOP_CODE(NOP_CODE)) u_exec (
        .clk         (clk),
        .rst_n       (rst_n),
        .end_cycle   (end_cycle),
        .flow_change (flow_change),
        .fetched     (fetched),
        .ir          (ir_word),
        .valid       (exec_valid)
    );

    qps_strobes u_strb (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_oh (phase_oh),
        .valid    (exec_valid),
        .pc_adv   (pc_adv),
        .ir_load  (ir_load),
        .op_rd    (op_rd),
        .dst_wr   (dst_wr)
    );

    assign q1 = phase_oh[0];
    assign q2 = phase_oh[1];
    assign q3 = phase_oh[2];
    assign q4 = phase_oh[3];

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (q1 && !exec_valid && ir_word == NOP_CODE));
    p_rd_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        op_rd |-> (q2 && exec_valid));
    p_wr_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dst_wr |-> (q4 && exec_valid));
endmodule

// File: tb/test_qphase_seq.sv
`timescale 1ns/1ps
module test_qphase_seq;
    localparam int            IW   = 16;
    localparam logic [IW-1:0] NOPW = '0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] instr_word = '0;
    logic          flow_change = 1'b0;
    logic          q1, q2, q3, q4, pc_adv, ir_load, op_rd, dst_wr, exec_valid;
    logic [IW-1:0] ir_word;

    qphase_seq #(.IW(IW), .NOP_CODE(NOPW)) i_qphase_seq (
        .clk(clk), .rst_n(rst_n), .instr_word(instr_word), .flow_change(flow_change),
        .q1(q1), .q2(q2), .q3(q3), .q4(q4), .pc_adv(pc_adv), .ir_load(ir_load),
        .op_rd(op_rd), .dst_wr(dst_wr), .ir_word(ir_word), .exec_valid(exec_valid)
    );

    always #10 clk = ~clk;   // 50 MHz

    int            checks = 0;
    int            fails  = 0;
    bit            done   = 0;
    logic [IW:0]   expq[$];
    string         tagq[$];
    logic [IW-1:0] cur_ir    = NOPW;
    logic          cur_valid = 1'b0;
    logic          last_sq   = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_phase(input int ph);
        logic [3:0] exp_oh;
        exp_oh = 4'b0001 << ph;
        chk({q4, q3, q2, q1} == exp_oh, "R2", "phase", 32'({q4, q3, q2, q1}), 32'(exp_oh));
        chk(pc_adv == (ph == 0) && ir_load == (ph == 0), "R3", "pc_adv/ir_load",
            32'({pc_adv, ir_load}), (ph == 0) ? 32'h3 : 32'h0);
        chk(op_rd == (ph == 1 && cur_valid), "R5", "op_rd", 32'(op_rd), 32'(ph == 1 && cur_valid));
        chk(dst_wr == (ph == 3 && cur_valid), "R5", "dst_wr", 32'(dst_wr), 32'(ph == 3 && cur_valid));
        if (ph > 0) begin
            chk(ir_word == cur_ir, "R4", "ir hold", 32'(ir_word), 32'(cur_ir));
            chk(exec_valid == cur_valid, "R4", "valid hold", 32'(exec_valid), 32'(cur_valid));
        end
    endtask

    // driver: one instruction cycle; entered and left at the negedge inside Q1
    task automatic run_cycle(input logic [IW-1:0] word, input bit noise, input bit force_q4);
        logic  fc;
        logic  sq;
        string tag;
        fc = (cur_valid && cur_ir[IW-1]) || force_q4;   // opcode stub: msb = branch
        for (int ph = 0; ph < 4; ph++) begin
            if (ph > 0) @(negedge clk);
            instr_word  = (ph == 3) ? ~word : word;     // corrupt after the fetch edge
            flow_change = (ph == 3) ? fc : noise;
            check_phase(ph);
        end
        sq = fc && cur_valid;
        if (sq)                     tag = "R7";
        else if (noise || force_q4) tag = "R9";
        else if (last_sq)           tag = "R8";
        else                        tag = "R6";
        expq.push_back({~sq, sq ? NOPW : word});
        tagq.push_back(tag);
        cur_ir    = sq ? NOPW : word;
        cur_valid = ~sq;
        last_sq   = sq;
        @(negedge clk);
    endtask

    // monitor: compare each new instruction-register load against the scoreboard
    always @(negedge clk) begin
        if (rst_n && q1 && expq.size() > 0) begin
            logic [IW:0] item;
            string       tag;
            item = expq.pop_front();
            tag  = tagq.pop_front();
            chk(ir_word == item[IW-1:0], tag, "ir_word", 32'(ir_word), 32'(item[IW-1:0]));
            chk(exec_valid == item[IW], tag, "exec_valid", 32'(exec_valid), 32'(item[IW]));
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({q4, q3, q2, q1} == 4'b0001, "R1", "reset phase", 32'({q4, q3, q2, q1}), 32'h1);
        chk(ir_word == NOPW && !exec_valid, "R1", "reset ir/valid", 32'({exec_valid, ir_word}), 32'h0);
        chk(!op_rd && !dst_wr, "R1", "reset strobes", 32'({op_rd, dst_wr}), 32'h0);
        rst_n = 1'b1;
        run_cycle(16'h0101, 0, 0);  // first cycle: nothing executes (R1)
        run_cycle(16'h0202, 0, 0);
        run_cycle(16'h8010, 0, 0);
        run_cycle(16'h0303, 0, 0);  // executes 8010 -> flush
        run_cycle(16'h0404, 0, 0);  // flush cycle fetches target
        run_cycle(16'h0505, 1, 0);  // early flag noise
        run_cycle(16'h8020, 0, 0);
        run_cycle(16'h8030, 0, 0);  // executes 8020 -> flush
        run_cycle(16'h0606, 0, 1);  // flag forced during flushed cycle
        run_cycle(16'h8040, 0, 0);
        run_cycle(16'h0707, 0, 0);  // executes 8040 -> flush
        run_cycle(16'h8050, 0, 0);  // target is a branch
        run_cycle(16'h0808, 0, 0);  // executes 8050 -> flush
        run_cycle(16'h0909, 0, 0);
        run_cycle(16'h0a0a, 0, 0);
        run_cycle(16'h0b0b, 0, 0);
        run_cycle(NOPW, 0, 0);
        @(negedge clk);
        chk(expq.size() == 0, "R6", "scoreboard drained", 32'(expq.size()), 32'h0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule